// File: doc/BRIEF.md
# Beam Spill Phase Sequencer

This block produces the repeating beam-spill cycle for a data-acquisition front end. A one-clock millisecond tick advances it through five active phases in a fixed order. Each phase has its own programmable length in milliseconds. A cycle begins when a start request arrives from the source that the mode input selects. The source can be a software pulse, one of two external start pulses, an internal period timer, or the rising edge of an external gate level.

Software can read the current phase as a one-hot code. It can also read the number of milliseconds spent in that phase and the number of spills completed. A gate output is active during the burst phase and stays active for a programmable number of milliseconds after the burst ends. A soft-reset input returns the block to its idle state and clears every counter. The configuration values arrive on plain input ports, which stand in for a register bank.

Top module: `spill_seq`

## Requirements
- R1: `phase` reports 0 while waiting, and 1 (accelerate), 2 (prepare), 4 (burst read), 8 (post readout) and 16 (flush) for the active phases. An uninterrupted cycle visits them in the order 1, 2, 4, 8, 16 and then returns to 0.
- R2: Each active phase lasts max(d,1) ticks of `ms_tick`, where d is its duration input. `timer_ms` is 0 on entry to a phase and rises by one on each tick within that phase.
- R3: Mode 1 starts on `sw_start`, mode 2 on `ttl_start` and mode 3 on `net_start`. A start pulse that is high for one clock while waiting moves `phase` to 1 at the next edge. Start inputs that do not belong to the selected mode have no effect.
- R4: A start request that arrives while `phase` is not 0 leaves `phase` and `timer_ms` unchanged, and it does not lengthen the cycle.
- R5: `spill_count` increments by one on the tick that ends the flush phase, and at no other time.
- R6: In mode 7, a start fires on every `period_ms`-th tick, counted from entry into the mode. The count runs whether or not a cycle is in progress.
- R7: In mode 0, and in the unused codes 5, 6 and 9 to 15, the block stays in phase 0. Any change of the mode value forces phase 0 with `timer_ms` at 0 on the next edge.
- R8: In mode 4, the phase goes to 4 and stays there, and `timer_ms` counts ticks without limit.
- R9: In mode 8, a rising edge of `ext_gate` starts a cycle. The burst phase then ends on the first tick that finds `ext_gate` low, whatever `dur_burst` holds.
- R10: `spill_gate` is high throughout phase 4. When the burst phase ends normally, it stays high for `gate_ext_ms` further ticks. Leaving phase 4 because of a mode change or a reset drops it at once.
- R11: While `soft_rst` is high, `phase`, `timer_ms`, `spill_count` and `spill_gate` are held at 0, and ticks and starts are ignored.
- R12: Synchronous `rst` puts all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-clock millisecond strobe |
| soft_rst | input | 1 | Soft reset, holds the block idle and clears counters |
| mode | input | 4 | Trigger mode select |
| sw_start | input | 1 | Software start pulse |
| ttl_start | input | 1 | External start pulse, first source |
| net_start | input | 1 | External start pulse, timing-network source |
| ext_gate | input | 1 | External gate level for mode 8 |
| dur_accel | input | 32 | Accelerate phase length, ms |
| dur_prep | input | 32 | Prepare phase length, ms |
| dur_burst | input | 32 | Burst read phase length, ms |
| dur_post | input | 32 | Post readout phase length, ms |
| dur_flush | input | 32 | Flush phase length, ms |
| period_ms | input | 32 | Internal period for mode 7, ms |
| gate_ext_ms | input | 32 | Gate stretch after the burst, ms |
| phase | output | 5 | One-hot phase code, 0 when waiting |
| timer_ms | output | 32 | Milliseconds in the current phase |
| spill_count | output | 32 | Completed spills |
| spill_gate | output | 1 | Burst gate with extension |

## Verification
The assertions assume that `ms_tick` is a single-clock strobe, and that the duration, period and extension inputs stay constant while a cycle is running. They also assume that `mode` changes only on clock edges. The bench changes configuration only while the block is waiting or under soft reset. It drives every input on the falling clock edge. Between ticks it always leaves at least one clock with `ms_tick` low, so starts and mode changes never land on an unplanned tick.

// File: rtl/spill_pkg.sv
package spill_pkg;

    typedef enum logic [4:0] {
        PH_WAIT  = 5'd0,
        PH_ACCEL = 5'd1,
        PH_PREP  = 5'd2,
        PH_READ  = 5'd4,
        PH_POST  = 5'd8,
        PH_FLUSH = 5'd16
    } phase_e;

    typedef enum logic [3:0] {
        MD_OFF  = 4'd0,
        MD_SOFT = 4'd1,
        MD_TTL  = 4'd2,
        MD_NET  = 4'd3,
        MD_INF  = 4'd4,
        MD_AUTO = 4'd7,
        MD_GATE = 4'd8
    } mode_e;

    typedef struct packed {
        logic start;
        logic mode_chg;
    } trig_t;

    localparam int unsigned NUM_PHASES = 5;

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_ACCEL: return PH_PREP;
            PH_PREP:  return PH_READ;
            PH_READ:  return PH_POST;
            PH_POST:  return PH_FLUSH;
            default:  return PH_WAIT;
        endcase
    endfunction

endpackage

// File: rtl/spill_trigger.sv
module spill_trigger
    import spill_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          ms_tick,
    input  logic [3:0]    mode,
    input  logic          sw_start,
    input  logic          ttl_start,
    input  logic          net_start,
    input  logic          ext_gate,
    input  logic [TW-1:0] period,
    output trig_t         trig
);

    mode_e         md;
    logic [3:0]    mode_q;
    logic          gate_q;
    logic [TW-1:0] per_cnt;
    logic          per_hit;

    assign md = mode_e'(mode);

    always_comb begin
        per_hit = (md == MD_AUTO) && ms_tick && ((per_cnt + TW'(1)) >= period);
        trig.mode_chg = (mode != mode_q);
        case (md)
            MD_SOFT: trig.start = sw_start;
            MD_TTL:  trig.start = ttl_start;
            MD_NET:  trig.start = net_start;
            MD_AUTO: trig.start = per_hit;
            MD_GATE: trig.start = ext_gate && !gate_q;
            default: trig.start = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            gate_q  <= 1'b0;
            per_cnt <= '0;
        end else begin
            mode_q <= mode;
            gate_q <= ext_gate;
            if (soft_rst || md != MD_AUTO || trig.mode_chg)
                per_cnt <= '0;
            else if (ms_tick)
                per_cnt <= per_hit ? '0 : per_cnt + TW'(1);
        end
    end

    // R6
    period_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (md != MD_AUTO) |=> (per_cnt == '0));

endmodule

// File: rtl/spill_phase_fsm.sv
module spill_phase_fsm
    import spill_pkg::*;
#(
    parameter int TW = 32,
    parameter int CW = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         soft_rst,
    input  logic                         ms_tick,
    input  logic [3:0]                   mode,
    input  trig_t                        trig,
    input  logic                         ext_gate,
    input  logic [NUM_PHASES-1:0][TW-1:0] dur,
    output phase_e                       phase,
    output logic [TW-1:0]                timer,
    output logic [CW-1:0]                count,
    output logic                         leave_read
);

    mode_e         md;
    logic [TW-1:0] dur_cur;
    logic          advance;

    assign md = mode_e'(mode);

    always_comb begin
        case (phase)
            PH_ACCEL: dur_cur = dur[0];
            PH_PREP:  dur_cur = dur[1];
            PH_READ:  dur_cur = dur[2];
            PH_POST:  dur_cur = dur[3];
            default:  dur_cur = dur[4];
        endcase
        if (md == MD_GATE && phase == PH_READ)
            advance = ms_tick && !ext_gate;
        else
            advance = ms_tick && ((timer + TW'(1)) >= dur_cur);
        leave_read = !soft_rst && !trig.mode_chg && md != MD_INF &&
                     phase == PH_READ && advance;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            phase <= PH_WAIT;
            timer <= '0;
            count <= '0;
        end else if (trig.mode_chg) begin
            phase <= PH_WAIT;
            timer <= '0;
        end else if (md == MD_INF) begin
            phase <= PH_READ;
            if (ms_tick) timer <= timer + TW'(1);
        end else if (phase == PH_WAIT) begin
            if (trig.start) phase <= PH_ACCEL;
            timer <= '0;
        end else if (advance) begin
            phase <= next_phase(phase);
            timer <= '0;
            if (phase == PH_FLUSH) count <= count + CW'(1);
        end else if (ms_tick) begin
            timer <= timer + TW'(1);
        end
    end

    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase));

    // R4
    running_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ms_tick && !soft_rst && !trig.mode_chg && phase != PH_WAIT) |=> $stable(phase));

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase != PH_FLUSH || !ms_tick) && !soft_rst) |=> $stable(count));

    // R7
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (md == MD_OFF) |=> (phase == PH_WAIT));

    // R8
    infinite_chk: assert property (@(posedge clk) disable iff (rst)
        (md == MD_INF && !trig.mode_chg && !soft_rst) |=> (phase == PH_READ));

    // R11
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (phase == PH_WAIT && count == '0 && timer == '0));

endmodule

// File: rtl/spill_gate_ext.sv
module spill_gate_ext
    import spill_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_rst,
    input  logic          ms_tick,
    input  phase_e        phase,
    input  logic          leave_read,
    input  logic [TW-1:0] gate_ext,
    output logic          gate
);

    logic [TW-1:0] ext_cnt;

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            ext_cnt <= '0;
        else if (leave_read)
            ext_cnt <= gate_ext;
        else if (ms_tick && ext_cnt != '0)
            ext_cnt <= ext_cnt - TW'(1);
    end

    assign gate = (phase == PH_READ) || (ext_cnt != '0);

    // R10
    gate_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        (leave_read && gate_ext != '0) |=> gate);

    // R10
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!leave_read && !ms_tick && !soft_rst) |=> $stable(ext_cnt));

endmodule

// File: rtl/spill_seq.sv
module spill_seq
    import spill_pkg::*;
#(
    parameter int TW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ms_tick,
    input  logic          soft_rst,
    input  logic [3:0]    mode,
    input  logic          sw_start,
    input  logic          ttl_start,
    input  logic          net_start,
    input  logic          ext_gate,
    input  logic [TW-1:0] dur_accel,
    input  logic [TW-1:0] dur_prep,
    input  logic [TW-1:0] dur_burst,
    input  logic [TW-1:0] dur_post,
    input  logic [TW-1:0] dur_flush,
    input  logic [TW-1:0] period_ms,
    input  logic [TW-1:0] gate_ext_ms,
    output logic [4:0]    phase,
    output logic [TW-1:0] timer_ms,
    output logic [CW-1:0] spill_count,
    output logic          spill_gate
);

    trig_t                          trig;
    phase_e                         ph;
    logic                           leave_read;
    logic [NUM_PHASES-1:0][TW-1:0]  dur_vec;

    assign dur_vec = {dur_flush, dur_post, dur_burst, dur_prep, dur_accel};

    spill_trigger #(.TW(TW)) u_trig (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .ms_tick(ms_tick),
        .mode(mode), .sw_start(sw_start), .ttl_start(ttl_start),
        .net_start(net_start), .ext_gate(ext_gate), .period(period_ms),
        .trig(trig)
    );

    spill_phase_fsm #(.TW(TW), .CW(CW)) u_fsm (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .ms_tick(ms_tick),
        .mode(mode), .trig(trig), .ext_gate(ext_gate), .dur(dur_vec),
        .phase(ph), .timer(timer_ms), .count(spill_count),
        .leave_read(leave_read)
    );

    spill_gate_ext #(.TW(TW)) u_gate (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .ms_tick(ms_tick),
        .phase(ph), .leave_read(leave_read), .gate_ext(gate_ext_ms),
        .gate(spill_gate)
    );

    assign phase = ph;

endmodule

// File: tb/tb_spill_seq.sv
`timescale 1ns/1ps
module tb_spill_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ms_tick = 1'b0, soft_rst = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        sw_start = 1'b0, ttl_start = 1'b0, net_start = 1'b0, ext_gate = 1'b0;
    logic [31:0] d0 = 1, d1 = 1, d2 = 1, d3 = 1, d4 = 1, period = 8, gext = 0;
    logic [4:0]  phase;
    logic [31:0] timer_ms, spill_count;
    logic        spill_gate;

    int tests = 0, fails = 0, cyc = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    spill_seq dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .soft_rst(soft_rst), .mode(mode),
        .sw_start(sw_start), .ttl_start(ttl_start), .net_start(net_start),
        .ext_gate(ext_gate), .dur_accel(d0), .dur_prep(d1), .dur_burst(d2),
        .dur_post(d3), .dur_flush(d4), .period_ms(period), .gate_ext_ms(gext),
        .phase(phase), .timer_ms(timer_ms), .spill_count(spill_count),
        .spill_gate(spill_gate)
    );

    typedef struct packed {
        logic [7:0]  a, p, b, q, f, g;
        logic [15:0] exp_len;
        logic [15:0] exp_gate;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd0, 16'd5,  16'd1},
        '{8'd2, 8'd3, 8'd4, 8'd1, 8'd2, 8'd2, 16'd12, 16'd6},
        '{8'd0, 8'd0, 8'd3, 8'd0, 8'd0, 8'd1, 16'd7,  16'd4},
        '{8'd3, 8'd1, 8'd5, 8'd2, 8'd1, 8'd3, 16'd12, 16'd8},
        '{8'd1, 8'd2, 8'd2, 8'd4, 8'd3, 8'd5, 16'd12, 16'd7}
    };

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: sw_start = 1'b1;
            1: ttl_start = 1'b1;
            default: net_start = 1'b1;
        endcase
        @(negedge clk);
        sw_start = 1'b0; ttl_start = 1'b0; net_start = 1'b0;
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk) mode = m;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        // R12 reset state
        chk(phase == 0 && timer_ms == 0 && spill_count == 0 && spill_gate == 0,
            "R12 reset", phase, 0);

        set_mode(4'd1);
        // R1 R2 R5 R10 table of cycles in software mode
        foreach (VECS[v]) begin
            int n, gc;
            logic [4:0]  prev;
            logic [31:0] prev_t;
            d0 = VECS[v].a; d1 = VECS[v].p; d2 = VECS[v].b;
            d3 = VECS[v].q; d4 = VECS[v].f; gext = 32'(VECS[v].g);
            pulse(0);
            chk(phase == 5'd1 && timer_ms == 0, "R3 sw start", phase, 1);
            n = 0; gc = 0;
            prev = phase; prev_t = timer_ms;
            while (phase != 0 && n < 200) begin
                tick(); n++;
                if (spill_gate) gc++;
                if (phase == prev)
                    chk(timer_ms == prev_t + 1, "R2 timer step", timer_ms, prev_t + 1);
                else begin
                    chk(phase == ((prev == 5'd16) ? 5'd0 : 5'(prev << 1)), "R1 order",
                        phase, (prev == 5'd16) ? 0 : prev << 1);
                    chk(timer_ms == 0, "R2 timer reload", timer_ms, 0);
                end
                prev = phase; prev_t = timer_ms;
            end
            for (int k = 0; k < 8; k++) begin
                tick();
                if (spill_gate) gc++;
            end
            exp_cnt++;
            chk(n == int'(VECS[v].exp_len), "R2 cycle length", n, VECS[v].exp_len);
            chk(gc == int'(VECS[v].exp_gate), "R10 gate ticks", gc, VECS[v].exp_gate);
            chk(spill_count == 32'(exp_cnt), "R5 count", spill_count, exp_cnt);
        end

        // R4 start during a cycle
        d0 = 1; d1 = 1; d2 = 5; d3 = 1; d4 = 1; gext = 0;
        pulse(0);
        ticks(3);
        pulse(0);
        chk(phase == 5'd4 && timer_ms == 1, "R4 ignore phase", phase, 4);
        ticks(5);
        chk(phase == 5'd16, "R4 no stretch", phase, 16);
        tick();
        exp_cnt++;
        chk(phase == 0 && spill_count == 32'(exp_cnt), "R5 after ignore", spill_count, exp_cnt);

        // R3 source selection
        set_mode(4'd2);
        pulse(0); pulse(2);
        chk(phase == 0, "R3 foreign start", phase, 0);
        pulse(1);
        chk(phase == 5'd1, "R3 ttl start", phase, 1);
        tick();
        set_mode(4'd3);
        chk(phase == 0 && timer_ms == 0, "R7 mode change abort", phase, 0);
        pulse(2);
        chk(phase == 5'd1, "R3 net start", phase, 1);

        // R7 off and unused codes
        set_mode(4'd0);
        pulse(0); pulse(1); pulse(2); tick();
        chk(phase == 0, "R7 off", phase, 0);
        set_mode(4'd5);
        pulse(0); pulse(1); pulse(2);
        chk(phase == 0, "R7 unused code", phase, 0);

        // R8 infinite
        set_mode(4'd4);
        idle(1);
        chk(phase == 5'd4 && timer_ms == 0, "R8 enter", phase, 4);
        ticks(10);
        chk(phase == 5'd4 && timer_ms == 10 && spill_gate, "R8 hold", timer_ms, 10);
        gext = 3;
        set_mode(4'd1);
        chk(phase == 0 && !spill_gate, "R10 abort drops gate", spill_gate, 0);

        // R6 auto period
        d0 = 1; d1 = 1; d2 = 1; d3 = 1; d4 = 1; gext = 0; period = 8;
        set_mode(4'd7);
        ticks(7);
        chk(phase == 0, "R6 before period", phase, 0);
        tick();
        chk(phase == 5'd1, "R6 first start", phase, 1);
        ticks(8);
        exp_cnt++;
        chk(phase == 5'd1 && spill_count == 32'(exp_cnt), "R6 second start", spill_count, exp_cnt);
        set_mode(4'd0);

        // R9 gate mode
        d2 = 2;
        set_mode(4'd8);
        @(negedge clk) ext_gate = 1'b1;
        @(negedge clk);
        chk(phase == 5'd1, "R9 gate start", phase, 1);
        ticks(2);
        chk(phase == 5'd4, "R9 burst", phase, 4);
        ticks(10);
        chk(phase == 5'd4 && timer_ms == 10, "R9 burst held", timer_ms, 10);
        @(negedge clk) ext_gate = 1'b0;
        @(negedge clk);
        chk(phase == 5'd4, "R9 waits for tick", phase, 4);
        tick();
        chk(phase == 5'd8, "R9 burst end", phase, 8);
        ticks(2);
        exp_cnt++;
        chk(phase == 0 && spill_count == 32'(exp_cnt), "R9 complete", spill_count, exp_cnt);

        // R11 soft reset
        set_mode(4'd1);
        d2 = 3; gext = 4;
        pulse(0); ticks(3);
        @(negedge clk) soft_rst = 1'b1;
        @(negedge clk) begin ms_tick = 1'b1; sw_start = 1'b1; end
        @(negedge clk) begin ms_tick = 1'b0; sw_start = 1'b0; end
        chk(phase == 0 && timer_ms == 0 && spill_count == 0 && !spill_gate,
            "R11 soft reset", spill_count, 0);
        @(negedge clk) soft_rst = 1'b0;
        pulse(0);
        chk(phase == 5'd1, "R11 restart", phase, 1);
        ticks(7);
        chk(phase == 0 && spill_count == 1, "R11 count restarts", spill_count, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule